// File: doc/BRIEF.md
# Graphic LCD Controller Command Interpreter

This block is the slave side of a small monochrome graphic LCD controller. A host drives it over an 8-bit parallel bus: a register-select line and a read/write line choose the kind of access, and a one-cycle strobe marks each access. Command writes set the display enable, the first panel line shown, the segment direction flag and a 6-bit reference-voltage parameter. That parameter arrives as a two-byte sequence. Other commands load a page pointer and a column pointer into an internal display memory of 8 pages by 128 columns of bytes.

Data writes store a byte at the current page and column. Data reads return the byte stored there. After either data access the column moves on by one, so the host can stream along a page. Status reads return a byte with a busy flag, the direction flag, the display flag and an initialisation flag. After reset the block spends a fixed number of cycles initialising. During that time it reports busy and acts on nothing except status reads.

The register contents and the busy flag are brought out on debug ports so that they can be observed.

Top module: `glcd_cmd_core`

## Requirements
- R1: The access kind is `{bus_rs, bus_rw}`. The value 2'b00 is a command write, 2'b01 a status read, 2'b10 a data write and 2'b11 a data read. Each access is taken on the clock edge where `bus_valid` is high.
- R2: A data write stores `bus_wdata` at memory address page*128+column. A data read loads `bus_rdata` with that byte on the same edge. In both cases the column then increases by one and the page is left unchanged.
- R3: When the column increases from 127 it wraps to 0, and the page does not change.
- R4: A status read loads `bus_rdata` with busy in bit 7, direction in bit 6, display-on in bit 5 and initialising in bit 4. Bits 3..0 are zero.
- R5: For INIT_CYCLES clocks after reset ends, busy and initialising read 1. In that window command writes, data writes and data reads have no effect on registers, pointers, memory or `bus_rdata`. Status reads still work.
- R6: Command 8'hAF sets the display on and command 8'hAE sets it off.
- R7: A command of the form 2'b01 followed by a 6-bit value loads that value into the start-line register.
- R8: Command 8'h81 sets the pending flag. The next command write is always taken as the parameter, whatever its value: bits 5..0 go into the reference register, bits 7..6 are ignored, and the pending flag clears.
- R9: Command 8'hB0+p (p = 0..7) loads the page. Command 8'h10+h (h = 0..7) loads column bits 6..4. Command 8'h00+l (l = 0..15) loads column bits 3..0.
- R10: Command 8'hA0 clears the direction flag and command 8'hA1 sets it.
- R11: Command bytes matching none of the encodings in R6 to R10 leave every register and pointer unchanged.
- R12: Reset clears the display flag, start line, reference parameter, pending flag, direction flag, page, column and `bus_rdata`.
- R13: `bus_rdata` changes only on a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_rs | input | 1 | Register select: 1 selects display data |
| bus_rw | input | 1 | Direction: 1 selects read |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |
| dbg_busy | output | 1 | Initialisation in progress |
| dbg_disp_on | output | 1 | Display enable flag |
| dbg_adc | output | 1 | Segment direction flag |
| dbg_start_line | output | 6 | Start-line register |
| dbg_vref | output | 6 | Reference-voltage parameter |
| dbg_vref_pending | output | 1 | Waiting for the parameter byte |
| dbg_page | output | 3 | Page pointer |
| dbg_col | output | 7 | Column pointer |

## Verification
The bench builds the block with INIT_CYCLES set to 12. This keeps the busy window short enough to probe every access kind inside it and to see its exact last cycle. A second reset partway through the run checks that the window starts again. The geometry stays at its default of 128 columns, so streaming a full page of writes and then of reads carries the column across the 127-to-0 wrap. Parameter bytes that look like display, page and unknown commands check that the pending state takes priority over decoding.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

    localparam int DW     = 8;
    localparam int PAGE_W = 3;
    localparam int COL_W  = 7;
    localparam int LINE_W = 6;
    localparam int VREF_W = 6;
    localparam int ADDR_W = PAGE_W + COL_W;
    localparam int DEPTH  = 1 << ADDR_W;

    // {rs, rw}
    typedef enum logic [1:0] {
        ACC_CMD  = 2'b00,
        ACC_STAT = 2'b01,
        ACC_DWR  = 2'b10,
        ACC_DRD  = 2'b11
    } acc_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_DISP,
        OP_LINE,
        OP_VMODE,
        OP_VPARAM,
        OP_ADC,
        OP_PAGE,
        OP_COLHI,
        OP_COLLO
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [5:0]      arg;
    } cmd_t;

    typedef struct packed {
        logic              disp_on;
        logic              adc;
        logic [LINE_W-1:0] line;
        logic [VREF_W-1:0] vref;
        logic              vpend;
    } regs_t;

    function automatic cmd_t decode_cmd(input logic [DW-1:0] b, input logic pend);
        cmd_t c;
        c.arg = b[5:0];
        if (pend)                     c.op = OP_VPARAM;
        else if (b[7:1] == 7'b1010111) c.op = OP_DISP;
        else if (b[7:6] == 2'b01)      c.op = OP_LINE;
        else if (b == 8'h81)           c.op = OP_VMODE;
        else if (b[7:1] == 7'b1010000) c.op = OP_ADC;
        else if (b[7:3] == 5'b10110)   c.op = OP_PAGE;
        else if (b[7:3] == 5'b00010)   c.op = OP_COLHI;
        else if (b[7:4] == 4'b0000)    c.op = OP_COLLO;
        else                           c.op = OP_NONE;
        return c;
    endfunction

    function automatic logic [DW-1:0] status_byte(input logic busy, input logic adc,
                                                  input logic on, input logic initing);
        return {busy, adc, on, initing, 4'b0000};
    endfunction

endpackage

// File: rtl/glcd_cmd_decode.sv
module glcd_cmd_decode
    import glcd_pkg::*;
(
    input  logic [DW-1:0] byte_in,
    input  logic          pend,
    output cmd_t          cmd
);
    always_comb cmd = decode_cmd(byte_in, pend);
endmodule

// File: rtl/glcd_init_timer.sv
module glcd_init_timer #(
    parameter int INIT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    output logic busy
);
    localparam int CW = $clog2(INIT_CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= CW'(INIT_CYCLES);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/glcd_addr_ptr.sv
module glcd_addr_ptr
    import glcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_page,
    input  logic              ld_colhi,
    input  logic              ld_collo,
    input  logic              advance,
    input  logic [3:0]        nib,
    output logic [PAGE_W-1:0] page,
    output logic [COL_W-1:0]  col
);
    always_ff @(posedge clk) begin
        if (rst) begin
            page <= '0;
            col  <= '0;
        end else begin
            if (ld_page)  page <= nib[PAGE_W-1:0];
            if (ld_colhi) col  <= {nib[COL_W-5:0], col[3:0]};
            if (ld_collo) col  <= {col[COL_W-1:4], nib};
            if (advance)  col  <= col + 1'b1;
        end
    end
endmodule

// File: rtl/glcd_dram.sv
module glcd_dram
    import glcd_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/glcd_cmd_core.sv
module glcd_cmd_core
    import glcd_pkg::*;
#(
    parameter int INIT_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_rs,
    input  logic              bus_rw,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              dbg_busy,
    output logic              dbg_disp_on,
    output logic              dbg_adc,
    output logic [LINE_W-1:0] dbg_start_line,
    output logic [VREF_W-1:0] dbg_vref,
    output logic              dbg_vref_pending,
    output logic [PAGE_W-1:0] dbg_page,
    output logic [COL_W-1:0]  dbg_col
);
    regs_t             regs;
    cmd_t              cmd;
    acc_e              acc;
    logic              busy;
    logic              cmd_go, wr_go, rd_go, st_go;
    logic [DW-1:0]     mem_rd;
    logic [PAGE_W-1:0] page;
    logic [COL_W-1:0]  col;

    assign acc    = acc_e'({bus_rs, bus_rw});
    assign cmd_go = bus_valid && !busy && (acc == ACC_CMD);
    assign wr_go  = bus_valid && !busy && (acc == ACC_DWR);
    assign rd_go  = bus_valid && !busy && (acc == ACC_DRD);
    assign st_go  = bus_valid && (acc == ACC_STAT);

    glcd_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
        .clk (clk),
        .rst (rst),
        .busy(busy)
    );

    glcd_cmd_decode u_dec (
        .byte_in(bus_wdata),
        .pend   (regs.vpend),
        .cmd    (cmd)
    );

    glcd_addr_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .ld_page (cmd_go && cmd.op == OP_PAGE),
        .ld_colhi(cmd_go && cmd.op == OP_COLHI),
        .ld_collo(cmd_go && cmd.op == OP_COLLO),
        .advance (wr_go || rd_go),
        .nib     (cmd.arg[3:0]),
        .page    (page),
        .col     (col)
    );

    glcd_dram u_ram (
        .clk  (clk),
        .we   (wr_go),
        .addr ({page, col}),
        .wdata(bus_wdata),
        .rdata(mem_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (cmd_go) begin
            case (cmd.op)
                OP_DISP:   regs.disp_on <= cmd.arg[0];
                OP_LINE:   regs.line    <= cmd.arg;
                OP_VMODE:  regs.vpend   <= 1'b1;
                OP_VPARAM: begin
                    regs.vref  <= cmd.arg;
                    regs.vpend <= 1'b0;
                end
                OP_ADC:    regs.adc     <= cmd.arg[0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata <= '0;
        else if (st_go) bus_rdata <= status_byte(busy, regs.adc, regs.disp_on, busy);
        else if (rd_go) bus_rdata <= mem_rd;
    end

    assign dbg_busy         = busy;
    assign dbg_disp_on      = regs.disp_on;
    assign dbg_adc          = regs.adc;
    assign dbg_start_line   = regs.line;
    assign dbg_vref         = regs.vref;
    assign dbg_vref_pending = regs.vpend;
    assign dbg_page         = page;
    assign dbg_col          = col;
endmodule

// File: rtl/glcd_cmd_core_chk.sv
module glcd_cmd_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_valid,
    input logic       bus_rs,
    input logic       bus_rw,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       dbg_busy,
    input logic       dbg_disp_on,
    input logic       dbg_adc,
    input logic [5:0] dbg_start_line,
    input logic [5:0] dbg_vref,
    input logic       dbg_vref_pending,
    input logic [2:0] dbg_page,
    input logic [6:0] dbg_col
);
    a_r2_col_step: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_rs && !dbg_busy && dbg_col != 7'd127)
        |=> (dbg_col == $past(dbg_col) + 7'd1) && $stable(dbg_page));

    a_r3_col_wrap: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_rs && !dbg_busy && dbg_col == 7'd127)
        |=> (dbg_col == 7'd0) && $stable(dbg_page));

    a_r4_status_low: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_rs && bus_rw) |=> (bus_rdata[3:0] == 4'd0));

    a_r5_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (dbg_busy && bus_valid && !(!bus_rs && bus_rw))
        |=> $stable(dbg_disp_on) && $stable(dbg_start_line) && $stable(dbg_vref)
            && $stable(dbg_page) && $stable(dbg_col) && $stable(bus_rdata));

    a_r8_param_take: assert property (@(posedge clk) disable iff (rst)
        (dbg_vref_pending && !dbg_busy && bus_valid && !bus_rs && !bus_rw)
        |=> !dbg_vref_pending && (dbg_vref == $past(bus_wdata[5:0]))
            && $stable(dbg_disp_on) && $stable(dbg_page));

    a_r12_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> !dbg_disp_on && !dbg_adc && dbg_start_line == 6'd0
            && dbg_vref == 6'd0 && !dbg_vref_pending && dbg_page == 3'd0
            && dbg_col == 7'd0 && bus_rdata == 8'd0 && dbg_busy);

    a_r13_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_rw) |=> $stable(bus_rdata));
endmodule

bind glcd_cmd_core glcd_cmd_core_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .bus_valid       (bus_valid),
    .bus_rs          (bus_rs),
    .bus_rw          (bus_rw),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .dbg_busy        (dbg_busy),
    .dbg_disp_on     (dbg_disp_on),
    .dbg_adc         (dbg_adc),
    .dbg_start_line  (dbg_start_line),
    .dbg_vref        (dbg_vref),
    .dbg_vref_pending(dbg_vref_pending),
    .dbg_page        (dbg_page),
    .dbg_col         (dbg_col)
);

// File: tb/glcd_cmd_core_bench.sv
module glcd_cmd_core_bench;
    localparam int INIT = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_valid = 1'b0;
    logic       bus_rs = 1'b0;
    logic       bus_rw = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       dbg_busy, dbg_disp_on, dbg_adc, dbg_vref_pending;
    logic [5:0] dbg_start_line, dbg_vref;
    logic [2:0] dbg_page;
    logic [6:0] dbg_col;

    always #10 clk = ~clk;

    glcd_cmd_core #(.INIT_CYCLES(INIT)) u_glcd_cmd_core (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_rs(bus_rs),
        .bus_rw(bus_rw), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_busy(dbg_busy), .dbg_disp_on(dbg_disp_on), .dbg_adc(dbg_adc),
        .dbg_start_line(dbg_start_line), .dbg_vref(dbg_vref),
        .dbg_vref_pending(dbg_vref_pending), .dbg_page(dbg_page), .dbg_col(dbg_col)
    );

    // behavioural reference model
    int  m_mem [1024];
    int  m_cnt, m_on, m_adc, m_line, m_vref, m_pend, m_page, m_col, m_rd;
    bit  m_rd_known;
    int  nvec = 0;
    int  nerr = 0;
    bit  done = 0;

    initial foreach (m_mem[i]) m_mem[i] = -1;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = INIT; m_on = 0; m_adc = 0; m_line = 0; m_vref = 0;
            m_pend = 0; m_page = 0; m_col = 0; m_rd = 0; m_rd_known = 1;
        end else begin
            bit b;
            int d;
            b = (m_cnt > 0);
            d = int'(bus_wdata);
            if (bus_valid) begin
                if (!bus_rs && bus_rw) begin                      // R1 status read
                    m_rd = (b ? 128 : 0) + m_adc * 64 + m_on * 32 + (b ? 16 : 0);
                    m_rd_known = 1;
                end else if (!b) begin
                    if (bus_rs && bus_rw) begin                   // R1 data read
                        int v;
                        v = m_mem[m_page * 128 + m_col];
                        if (v < 0) m_rd_known = 0;
                        else begin m_rd = v; m_rd_known = 1; end
                        m_col = (m_col + 1) % 128;
                    end else if (bus_rs) begin                    // R1 data write
                        m_mem[m_page * 128 + m_col] = d;
                        m_col = (m_col + 1) % 128;
                    end else if (m_pend != 0) begin
                        m_vref = d % 64; m_pend = 0;
                    end else if (d == 'hAF) m_on = 1;
                    else if (d == 'hAE) m_on = 0;
                    else if (d / 64 == 1) m_line = d % 64;
                    else if (d == 'h81) m_pend = 1;
                    else if (d == 'hA0 || d == 'hA1) m_adc = d % 2;
                    else if (d >= 'hB0 && d <= 'hB7) m_page = d - 'hB0;
                    else if (d >= 'h10 && d <= 'h17) m_col = (d - 'h10) * 16 + m_col % 16;
                    else if (d <= 'h0F) m_col = (m_col / 16) * 16 + d;
                end
            end
            if (m_cnt > 0) m_cnt--;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R5", "busy", int'(dbg_busy), (m_cnt > 0) ? 1 : 0);
            chk("R6", "disp_on", int'(dbg_disp_on), m_on);
            chk("R10", "adc", int'(dbg_adc), m_adc);
            chk("R7", "start_line", int'(dbg_start_line), m_line);
            chk("R8", "vref", int'(dbg_vref), m_vref);
            chk("R8", "pending", int'(dbg_vref_pending), m_pend);
            chk("R9", "page", int'(dbg_page), m_page);
            chk("R2", "col", int'(dbg_col), m_col);
            if (m_rd_known) chk("R13", "rdata", int'(bus_rdata), m_rd);
        end
    end

    task automatic acc(input bit rs, input bit rw, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_rs = rs; bus_rw = rw; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_valid = 1'b0;
        end
    endtask

    task automatic cmd(input logic [7:0] d); acc(1'b0, 1'b0, d); endtask

    initial begin
        // R12: reset state
        idle(3);
        rst = 1'b0;
        // R5: accesses inside the busy window
        cmd(8'hAF);
        acc(1'b1, 1'b0, 8'h5A);
        acc(1'b1, 1'b1, 8'h00);
        acc(1'b0, 1'b1, 8'h00);       // R4 status = 8'h90 while busy
        cmd(8'hB3);
        idle(INIT);
        acc(1'b0, 1'b1, 8'h00);       // R4 status ready
        // R6, R7
        cmd(8'hAF);
        cmd(8'h40 | 8'd37);
        // R8: parameter byte that looks like other commands
        cmd(8'h81); cmd(8'hAE);
        cmd(8'h81); cmd(8'hFF);
        cmd(8'h81); idle(2); cmd(8'hB4);
        // R10, R4
        cmd(8'hA1);
        acc(1'b0, 1'b1, 8'h00);
        // R9 pointers and R2 streaming
        cmd(8'hB5); cmd(8'h13); cmd(8'h0A);
        acc(1'b1, 1'b0, 8'h11); acc(1'b1, 1'b0, 8'h22); acc(1'b1, 1'b0, 8'h33);
        cmd(8'h13); cmd(8'h0A);
        acc(1'b1, 1'b1, 8'h00); acc(1'b1, 1'b1, 8'h00); acc(1'b1, 1'b1, 8'h00);
        idle(2);
        // R3 wrap
        cmd(8'hB2); cmd(8'h17); cmd(8'h0F);
        acc(1'b1, 1'b0, 8'hAA); acc(1'b1, 1'b0, 8'hBB);
        cmd(8'h17); cmd(8'h0F);
        acc(1'b1, 1'b1, 8'h00); acc(1'b1, 1'b1, 8'h00);
        // R11 unknown commands
        cmd(8'hFF); cmd(8'hE3); cmd(8'h20); cmd(8'h90); cmd(8'hB8); cmd(8'h18);
        idle(1);
        cmd(8'hAE); cmd(8'hA0);
        // full-page stream
        cmd(8'hB7); cmd(8'h10); cmd(8'h00);
        for (int i = 0; i < 130; i++) acc(1'b1, 1'b0, 8'((i * 3) + 1));
        for (int i = 0; i < 130; i++) acc(1'b1, 1'b1, 8'h00);
        idle(2);
        // second reset: R12 and R5 again
        @(negedge clk); bus_valid = 1'b0; rst = 1'b1;
        idle(2);
        rst = 1'b0;
        cmd(8'hAF); acc(1'b0, 1'b1, 8'h00);
        idle(INIT + 2);
        acc(1'b0, 1'b1, 8'h00);
        idle(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        #(20 * 200000);
        nerr++;
        $display("FAIL watchdog expired actual=0 expected=1");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule